// File: doc/BRIEF.md
# SIMT Warp Divergence Mask Unit

This unit keeps the set of enabled lanes for one warp of parallel threads that share a single instruction stream. Each lane sees the same instruction in the same cycle. When a branch depends on per-lane data, the unit splits the enabled set into the lanes that take the branch and the lanes that fall through. It runs the taken side first, then the fall-through side, and then it re-enables every lane that was enabled before the branch at the join address.

The unit keeps a stack that holds one entry per open divergent branch. An entry holds the enabled set from before the branch, the fall-through address and the join address. A one-bit phase flag beside each entry records whether the fall-through side has started. Because of this, a branch takes one write and one stack slot. If every enabled lane resolves the branch the same way, the unit changes only the next address and writes nothing to the stack.

The fetch stage raises a branch request with the per-lane condition and the three addresses. It raises a path-done strobe when the running path reaches its join address. The unit returns a registered lane mask and a registered next address.

Top module: `simt_mask_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `lane_mask` is all ones, `next_pc` equals `RESET_PC`, `stack_ovf` is 0 and the stack holds no entries.
- R2: A branch whose condition is 1 on every enabled lane sets `next_pc` to `br_target` one cycle later. `lane_mask` stays unchanged and no stack entry is written.
- R3: A branch whose condition is 0 on every enabled lane sets `next_pc` to `br_fall` one cycle later. `lane_mask` stays unchanged and no stack entry is written.
- R4: A divergent branch (condition 1 on some enabled lanes and 0 on others) sets `lane_mask` to condition AND old mask and sets `next_pc` to `br_target` one cycle later. It also writes one stack entry.
- R5: The first `path_done` on a stack entry sets `lane_mask` to the entry's saved mask AND NOT the current mask, and sets `next_pc` to the saved fall-through address.
- R6: The second `path_done` on a stack entry restores the saved mask, sets `next_pc` to the saved join address and removes the entry.
- R7: Condition bits of disabled lanes have no effect. A branch never enables a lane that was disabled before it.
- R8: Nested divergent branches unwind in last-in first-out order. The inner branch finishes both of its paths and rejoins before the outer branch switches paths.
- R9: A divergent branch that arrives while the stack holds `DEPTH` entries writes nothing to the stack and leaves `lane_mask` and `next_pc` unchanged. It also sets `stack_ovf`. Only reset clears `stack_ovf`. Uniform branches still work normally while the stack is full.
- R10: `path_done` while the stack is empty leaves `lane_mask` and `next_pc` unchanged.
- R11: When `path_done` and `br_valid` are high in the same cycle, only `path_done` takes effect and the branch is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch request for this cycle |
| br_cond | input | LANES | Per-lane branch condition (1 = taken) |
| br_target | input | PC_W | Taken-path address |
| br_fall | input | PC_W | Fall-through address |
| br_join | input | PC_W | Reconvergence address |
| path_done | input | 1 | The running path has reached its join address |
| lane_mask | output | LANES | Registered enabled-lane mask |
| next_pc | output | PC_W | Registered next fetch address |
| stack_ovf | output | 1 | Sticky stack-overflow flag |

## Verification
The bench builds the unit with 32 lanes and a 32-bit address, and sets the stack depth to 3. At that depth the overflow drop, the sticky flag and a full six-step unwind of three nested branches all fit in a few dozen cycles. Inner branches use conditions that disagree with the disabled lanes. This shows that those lanes stay off, and that a condition which looks divergent over all 32 lanes is treated as uniform when it is uniform over the enabled lanes.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

  // How the enabled lanes resolved a branch
  typedef enum logic [1:0] {
    BR_ALL_TAKEN  = 2'd0,
    BR_NONE_TAKEN = 2'd1,
    BR_SPLIT      = 2'd2
  } br_kind_e;

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] taken_mask,
  output br_kind_e         kind
);

  logic [LANES-1:0] fall_mask;

  // Lanes that are off never join either side.
  assign taken_mask = cond & cur_mask;
  assign fall_mask  = cur_mask & ~cond;

  always_comb begin
    if (fall_mask == '0)       kind = BR_ALL_TAKEN;
    else if (taken_mask == '0) kind = BR_NONE_TAKEN;
    else                       kind = BR_SPLIT;
  end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LANES-1:0] push_mask,
  input  logic [PC_W-1:0]  push_resume,
  input  logic [PC_W-1:0]  push_join,
  input  logic             pop,
  input  logic             mark,
  output logic [LANES-1:0] top_mask,
  output logic [PC_W-1:0]  top_resume,
  output logic [PC_W-1:0]  top_join,
  output logic             top_second,
  output logic             empty,
  output logic             full
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SP_W  = $clog2(DEPTH + 1);

  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;
  logic [DEPTH-1:0] second_q;

  // Entry storage: one write port, no reset, suitable for distributed RAM
  logic [LANES-1:0] mem_mask   [DEPTH];
  logic [PC_W-1:0]  mem_resume [DEPTH];
  logic [PC_W-1:0]  mem_join   [DEPTH];

  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));
  assign wr_idx  = IDX_W'(sp);
  assign top_idx = empty ? '0 : IDX_W'(sp - SP_W'(1));

  always_ff @(posedge clk) begin
    if (push) begin
      mem_mask[wr_idx]   <= push_mask;
      mem_resume[wr_idx] <= push_resume;
      mem_join[wr_idx]   <= push_join;
    end
  end

  assign top_mask   = mem_mask[top_idx];
  assign top_resume = mem_resume[top_idx];
  assign top_join   = mem_join[top_idx];
  assign top_second = second_q[top_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp       <= '0;
      second_q <= '0;
    end else if (push) begin
      sp               <= sp + SP_W'(1);
      second_q[wr_idx] <= 1'b0;
    end else if (pop) begin
      sp <= sp - SP_W'(1);
    end else if (mark) begin
      second_q[top_idx] <= 1'b1;
    end
  end

  // R9
  push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  // R10
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !(pop || mark));

  // R4
  push_fills_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> !empty);

endmodule

// File: rtl/simt_mask_unit.sv
module simt_mask_unit
  import simt_mask_pkg::*;
#(
  parameter int              LANES    = 32,
  parameter int              PC_W     = 32,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fall,
  input  logic [PC_W-1:0]  br_join,
  input  logic             path_done,
  output logic [LANES-1:0] lane_mask,
  output logic [PC_W-1:0]  next_pc,
  output logic             stack_ovf
);

  logic [LANES-1:0] mask_q;
  logic [PC_W-1:0]  pc_q;
  logic             ovf_q;

  logic [LANES-1:0] taken_mask;
  br_kind_e         kind;

  logic             st_push, st_pop, st_mark;
  logic [LANES-1:0] top_mask;
  logic [PC_W-1:0]  top_resume, top_join;
  logic             top_second, st_empty, st_full;

  simt_branch_eval #(.LANES(LANES)) u_eval (
    .cur_mask  (mask_q),
    .cond      (br_cond),
    .taken_mask(taken_mask),
    .kind      (kind)
  );

  simt_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst        (rst),
    .push       (st_push),
    .push_mask  (mask_q),
    .push_resume(br_fall),
    .push_join  (br_join),
    .pop        (st_pop),
    .mark       (st_mark),
    .top_mask   (top_mask),
    .top_resume (top_resume),
    .top_join   (top_join),
    .top_second (top_second),
    .empty      (st_empty),
    .full       (st_full)
  );

  // Stack control: path_done always wins over a branch in the same cycle
  always_comb begin
    st_push = 1'b0;
    st_pop  = 1'b0;
    st_mark = 1'b0;
    if (path_done) begin
      if (!st_empty) begin
        if (top_second) st_pop  = 1'b1;
        else            st_mark = 1'b1;
      end
    end else if (br_valid && kind == BR_SPLIT && !st_full) begin
      st_push = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pc_q   <= RESET_PC;
      ovf_q  <= 1'b0;
    end else if (path_done) begin
      if (!st_empty) begin
        if (!top_second) begin
          mask_q <= top_mask & ~mask_q;
          pc_q   <= top_resume;
        end else begin
          mask_q <= top_mask;
          pc_q   <= top_join;
        end
      end
    end else if (br_valid) begin
      case (kind)
        BR_ALL_TAKEN:  pc_q <= br_target;
        BR_NONE_TAKEN: pc_q <= br_fall;
        default: begin
          if (st_full) begin
            ovf_q <= 1'b1;
          end else begin
            mask_q <= taken_mask;
            pc_q   <= br_target;
          end
        end
      endcase
    end
  end

  assign lane_mask = mask_q;
  assign next_pc   = pc_q;
  assign stack_ovf = ovf_q;

  // R7
  no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !path_done) |=> ((lane_mask & ~$past(lane_mask)) == '0));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stack_ovf |=> stack_ovf);

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (path_done && st_empty) |=> ($stable(lane_mask) && $stable(next_pc)));

  // R5
  disjoint_paths_chk: assert property (@(posedge clk) disable iff (rst)
    (path_done && !st_empty && !top_second) |=> ((lane_mask & $past(lane_mask)) == '0));

endmodule

// File: tb/tb_simt_mask_unit.sv
`timescale 1ns/1ps
module tb_simt_mask_unit;

  localparam int LANES = 32;
  localparam int PC_W  = 32;
  localparam int DEPTH = 3;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic             clk = 1'b0;
  logic             rst;
  logic             br_valid;
  logic [LANES-1:0] br_cond;
  logic [PC_W-1:0]  br_target, br_fall, br_join;
  logic             path_done;
  logic [LANES-1:0] lane_mask;
  logic [PC_W-1:0]  next_pc;
  logic             stack_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  simt_mask_unit #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_cond(br_cond),
    .br_target(br_target), .br_fall(br_fall), .br_join(br_join),
    .path_done(path_done), .lane_mask(lane_mask), .next_pc(next_pc),
    .stack_ovf(stack_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [31:0] m, input logic [31:0] pc);
    chk({req, " mask"}, lane_mask, m);
    chk({req, " pc"}, next_pc, pc);
  endtask

  // One request cycle: drive at a falling edge, result visible at the next one
  task automatic cyc(input logic bv, input logic [31:0] c, input logic [31:0] t,
                     input logic [31:0] f, input logic [31:0] j, input logic pd);
    @(negedge clk);
    br_valid = bv; br_cond = c; br_target = t; br_fall = f; br_join = j; path_done = pd;
    @(negedge clk);
    br_valid = 1'b0; path_done = 1'b0;
  endtask

  task automatic branch(input logic [31:0] c, input logic [31:0] t,
                        input logic [31:0] f, input logic [31:0] j);
    cyc(1'b1, c, t, f, j, 1'b0);
  endtask

  task automatic done_step();
    cyc(1'b0, '0, '0, '0, '0, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1", 32'hFFFF_FFFF, RST_PC);
    chk("R1 ovf", {31'b0, stack_ovf}, 32'h0);
  endtask

  task automatic t_empty_done();
    done_step();
    chk_state("R10", 32'hFFFF_FFFF, RST_PC);
    // R11: branch beside path_done on empty stack is dropped
    cyc(1'b1, 32'h0000_00FF, 32'h777, 32'h778, 32'h779, 1'b1);
    chk_state("R11 empty", 32'hFFFF_FFFF, RST_PC);
  endtask

  task automatic t_uniform();
    branch(32'hFFFF_FFFF, 32'h200, 32'h204, 32'h2F0);
    chk_state("R2", 32'hFFFF_FFFF, 32'h200);
    branch(32'h0000_0000, 32'h300, 32'h304, 32'h3F0);
    chk_state("R3", 32'hFFFF_FFFF, 32'h304);
    done_step();
    chk_state("R2 R3 no entry", 32'hFFFF_FFFF, 32'h304);
  endtask

  task automatic t_diverge();
    branch(32'h0000_FFFF, 32'h400, 32'h404, 32'h500);
    chk_state("R4", 32'h0000_FFFF, 32'h400);
    done_step();
    chk_state("R5", 32'hFFFF_0000, 32'h404);
    done_step();
    chk_state("R6", 32'hFFFF_FFFF, 32'h500);
    done_step();
    chk_state("R6 popped", 32'hFFFF_FFFF, 32'h500);
  endtask

  task automatic t_nested_masked();
    branch(32'h0000_00FF, 32'h600, 32'h604, 32'h6F0);
    chk_state("R8 outer", 32'h0000_00FF, 32'h600);
    // R7: condition high on disabled lanes, uniform over enabled ones
    branch(32'hFFFF_FF00, 32'h610, 32'h614, 32'h61C);
    chk_state("R7 uniform", 32'h0000_00FF, 32'h614);
    branch(32'hFFFF_00F0, 32'h620, 32'h624, 32'h62C);
    chk_state("R7 split", 32'h0000_00F0, 32'h620);
    done_step();
    chk_state("R8 inner second", 32'h0000_000F, 32'h624);
    done_step();
    chk_state("R8 inner join", 32'h0000_00FF, 32'h62C);
    done_step();
    chk_state("R8 outer second", 32'hFFFF_FF00, 32'h604);
    done_step();
    chk_state("R8 outer join", 32'hFFFF_FFFF, 32'h6F0);
  endtask

  task automatic t_priority();
    branch(32'h0F0F_0F0F, 32'h700, 32'h704, 32'h7F0);
    chk_state("R11 setup", 32'h0F0F_0F0F, 32'h700);
    cyc(1'b1, 32'h0000_000F, 32'h710, 32'h714, 32'h71C, 1'b1);
    chk_state("R11", 32'hF0F0_F0F0, 32'h704);
    done_step();
    chk_state("R11 join", 32'hFFFF_FFFF, 32'h7F0);
  endtask

  task automatic t_overflow();
    branch(32'h7FFF_FFFF, 32'h800, 32'h804, 32'h8F0);
    branch(32'h3FFF_FFFF, 32'h810, 32'h814, 32'h81C);
    branch(32'h1FFF_FFFF, 32'h820, 32'h824, 32'h82C);
    chk_state("R9 fill", 32'h1FFF_FFFF, 32'h820);
    chk("R9 ovf clear", {31'b0, stack_ovf}, 32'h0);
    branch(32'h0FFF_FFFF, 32'h830, 32'h834, 32'h83C);
    chk_state("R9 drop", 32'h1FFF_FFFF, 32'h820);
    chk("R9 ovf set", {31'b0, stack_ovf}, 32'h1);
    branch(32'hFFFF_FFFF, 32'h840, 32'h844, 32'h84C);
    chk_state("R9 uniform while full", 32'h1FFF_FFFF, 32'h840);
    done_step(); chk_state("R9 unwind1", 32'h2000_0000, 32'h824);
    done_step(); chk_state("R9 unwind2", 32'h3FFF_FFFF, 32'h82C);
    done_step(); chk_state("R9 unwind3", 32'h4000_0000, 32'h814);
    done_step(); chk_state("R9 unwind4", 32'h7FFF_FFFF, 32'h81C);
    done_step(); chk_state("R9 unwind5", 32'h8000_0000, 32'h804);
    done_step(); chk_state("R9 unwind6", 32'hFFFF_FFFF, 32'h8F0);
    chk("R9 ovf sticky", {31'b0, stack_ovf}, 32'h1);
    do_reset();
    chk("R1 ovf cleared", {31'b0, stack_ovf}, 32'h0);
    chk_state("R1 after ovf", 32'hFFFF_FFFF, RST_PC);
  endtask

  initial begin
    rst = 1'b1; br_valid = 1'b0; br_cond = '0; br_target = '0;
    br_fall = '0; br_join = '0; path_done = 1'b0;
    t_reset();
    t_empty_done();
    t_uniform();
    t_diverge();
    t_nested_masked();
    t_priority();
    t_overflow();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule